// File: doc/BRIEF.md
# Weight-Load Elision Command Sequencer

This block sits in front of a weight-stationary systolic multiply array. It takes logical multiply requests and turns each one into a short stream of micro-commands. A LOAD command latches a weight tile into the array. A COMPUTE command streams activations through the latched tile. The block remembers which weight tile is resident for each pair of row-group and column-group codes. When a request finds its tile still resident, the LOAD is dropped and only the COMPUTE goes out, so a run of requests against one weight tile costs one command each.

The group codes are derived from the position and size of the tile on each axis of the array. The array is split into four equal quadrants per axis. Full-precision requests always expand into a fixed four-command sequence, and then every tag entry is invalidated. There are two other ways to invalidate entries. A tiling-reconfiguration pulse wipes the whole table. A write-snoop port retires any entry whose weight address was just overwritten. Requests arrive on a valid/ready port. Commands leave on a registered valid/ready port together with the accumulate flags: bit0 start, bit1 stop, bit2 accumulate.

Top module: `wtile_seq`

## Requirements
- R1: After reset `cmd_valid` is 0 and `req_ready` is 1, and the tag table is empty, so the first request always misses.
- R2: The group code of an axis depends on the tile size. With Q = ARRAY_DIM/4: a size of at most Q gives `1 << (pos/Q)`, which is 1, 2, 4 or 8. A size of at most 2Q gives 3 when pos < 2Q and 12 otherwise. Any larger size gives 15. `req_col_full`=1 forces the column code to 15. The codes appear on `cmd_row_grp` and `cmd_col_grp`.
- R3: A hit issues a single COMPUTE (`cmd_op`=1) that carries the request's flags. A hit needs a valid entry under the same (row code, column code) key with the same weight address and the same perf value.
- R4: A miss issues a LOAD (`cmd_op`=0, flags 0) followed by a COMPUTE with the request's flags. The entry for that key is then written with the new address and perf value.
- R5: A full-precision request issues four commands in this order: LOAD, COMPUTE with flags 3'b001, LOAD, COMPUTE with flags 3'b010. It then invalidates every entry.
- R6: A `tile_cfg_chg` pulse invalidates every entry. A request accepted in the same cycle as the pulse is treated as a miss.
- R7: A `wr_snoop_valid` pulse invalidates every entry whose stored address equals `wr_snoop_addr`, and leaves other entries untouched. A request accepted in the same cycle as a matching snoop is treated as a miss.
- R8: `cmd_valid` and all the command fields hold steady while `cmd_ready` is low. `req_ready` is high only when at most one command of earlier requests is still pending and that command is being taken in the same cycle.
- R9: A COMPUTE never leaves ahead of the LOAD it depends on. The commands of each request leave contiguously, in request order.
- R10: A request that matches the key and address of an entry but carries a different perf value is a miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_row_pos | input | POS_W | Row (contraction) start lane of the weight tile |
| req_row_size | input | POS_W+1 | Row extent of the tile |
| req_col_pos | input | POS_W | Column start lane of the tile |
| req_col_size | input | POS_W+1 | Column extent of the tile |
| req_col_full | input | 1 | Force the column group to the full axis |
| req_waddr | input | ADDR_W | Weight memory address of the tile |
| req_perf | input | PERF_W | Packing-mode signature |
| req_fullprec | input | 1 | Full-precision request, expands to two passes |
| req_flags | input | 3 | Accumulate flags: bit0 start, bit1 stop, bit2 accumulate |
| tile_cfg_chg | input | 1 | Tiling reconfiguration, clears the table |
| wr_snoop_valid | input | 1 | Weight memory write observed |
| wr_snoop_addr | input | ADDR_W | Address of the observed write |
| cmd_valid | output | 1 | Micro-command present |
| cmd_ready | input | 1 | Downstream takes the command |
| cmd_op | output | 1 | 0 = LOAD stationary, 1 = COMPUTE |
| cmd_row_grp | output | 4 | Row group code |
| cmd_col_grp | output | 4 | Column group code |
| cmd_waddr | output | ADDR_W | Weight address |
| cmd_perf | output | PERF_W | Packing-mode signature |
| cmd_flags | output | 3 | Accumulate flags for this command |

## Verification
The bench builds the block with its default values: a 128-lane array, 16-bit weight addresses and a 3-bit perf field. With 128 lanes, every one of the seven group codes can be reached on each axis, and all 49 populated table keys can be reached as well. Keys that differ only in quadrant, half or full span are driven side by side, so each lookup shows whether it lands on the right entry. Address values are drawn from a small pool, so hits, perf mismatches and snoops that match stored entries all occur often, both on their own and in the same cycle as an accepted request.

// File: rtl/wtile_pkg.sv
package wtile_pkg;
  // Command opcodes
  localparam logic OP_LOAD    = 1'b0;
  localparam logic OP_COMPUTE = 1'b1;

  // Accumulate flag vector: bit0 start, bit1 stop, bit2 accumulate
  typedef logic [2:0] acc_flags_t;
  localparam acc_flags_t FLG_NONE  = 3'b000;
  localparam acc_flags_t FLG_START = 3'b001;
  localparam acc_flags_t FLG_STOP  = 3'b010;

  // Group code and its compact class index (seven legal codes per axis)
  typedef logic [3:0] grp_t;
  localparam int CLS_W = 3;
  localparam grp_t GRP_FULL = 4'hF;
endpackage

// File: rtl/wtile_grp_enc.sv
module wtile_grp_enc
  import wtile_pkg::*;
#(
  parameter int ARRAY_DIM = 128,
  localparam int POS_W  = $clog2(ARRAY_DIM),
  localparam int SIZE_W = POS_W + 1
) (
  input  logic [POS_W-1:0]  pos,
  input  logic [SIZE_W-1:0] size,
  input  logic              force_full,
  output grp_t              grp,
  output logic [CLS_W-1:0]  cls
);
  localparam int QUAD = ARRAY_DIM / 4;

  logic [1:0] quad;
  logic       upper;

  always_comb begin
    quad  = 2'(pos >> (POS_W - 2));
    upper = 1'(pos >> (POS_W - 1));
    if (force_full) begin
      grp = GRP_FULL;
      cls = CLS_W'(6);
    end else if (size <= SIZE_W'(QUAD)) begin
      grp = grp_t'(4'b0001 << quad);
      cls = {1'b0, quad};
    end else if (size <= SIZE_W'(2 * QUAD)) begin
      grp = upper ? 4'hC : 4'h3;
      cls = {2'b10, upper};
    end else begin
      grp = GRP_FULL;
      cls = CLS_W'(6);
    end
  end
endmodule

// File: rtl/wtile_tag_table.sv
module wtile_tag_table
  import wtile_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int PERF_W = 3,
  localparam int IDX_W = 2 * CLS_W,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  lk_idx,
  input  logic [ADDR_W-1:0] lk_addr,
  input  logic [PERF_W-1:0] lk_perf,
  output logic              lk_hit,
  input  logic              clr_all,
  input  logic              snoop_v,
  input  logic [ADDR_W-1:0] snoop_addr,
  input  logic              ins_en,
  input  logic [IDX_W-1:0]  ins_idx,
  input  logic [ADDR_W-1:0] ins_addr,
  input  logic [PERF_W-1:0] ins_perf
);
  logic [DEPTH-1:0]  ent_vld;
  logic [ADDR_W-1:0] ent_addr [DEPTH];
  logic [PERF_W-1:0] ent_perf [DEPTH];

  // Same-cycle invalidations take priority over the lookup
  always_comb begin
    lk_hit = ent_vld[lk_idx]
           && (ent_addr[lk_idx] == lk_addr)
           && (ent_perf[lk_idx] == lk_perf)
           && !clr_all
           && !(snoop_v && (snoop_addr == ent_addr[lk_idx]));
  end

  // Valid bits: clears first, a same-cycle insert wins
  always_ff @(posedge clk) begin
    if (rst) begin
      ent_vld <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (clr_all || (snoop_v && (ent_addr[i] == snoop_addr)))
          ent_vld[i] <= 1'b0;
      end
      if (ins_en)
        ent_vld[ins_idx] <= 1'b1;
    end
  end

  // Payload: plain write port, no reset
  always_ff @(posedge clk) begin
    if (ins_en) begin
      ent_addr[ins_idx] <= ins_addr;
      ent_perf[ins_idx] <= ins_perf;
    end
  end

  // R6
  clear_all_chk: assert property (@(posedge clk) disable iff (rst)
    clr_all && !ins_en |=> (ent_vld == '0));

  // R4
  insert_hit_chk: assert property (@(posedge clk) disable iff (rst)
    ins_en |=> ent_vld[$past(ins_idx)]);
endmodule

// File: rtl/wtile_issue.sv
module wtile_issue
  import wtile_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int PERF_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_fp,
  input  logic              req_hit,
  input  grp_t              req_rgrp,
  input  grp_t              req_cgrp,
  input  logic [ADDR_W-1:0] req_waddr,
  input  logic [PERF_W-1:0] req_perf,
  input  acc_flags_t        req_flags,
  output logic              req_fire,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic              cmd_op,
  output grp_t              cmd_row_grp,
  output grp_t              cmd_col_grp,
  output logic [ADDR_W-1:0] cmd_waddr,
  output logic [PERF_W-1:0] cmd_perf,
  output acc_flags_t        cmd_flags
);
  logic [1:0]  rem;      // commands still to be placed after the current one
  logic        h_fp;
  acc_flags_t  h_flags;
  logic        adv;

  assign adv       = !cmd_valid || cmd_ready;
  assign req_ready = (rem == 2'd0) && adv;
  assign req_fire  = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_valid <= 1'b0;
      rem       <= 2'd0;
    end else if (adv) begin
      if (rem != 2'd0) begin
        cmd_valid <= 1'b1;
        rem       <= rem - 2'd1;
        if (!h_fp) begin
          cmd_op    <= OP_COMPUTE;
          cmd_flags <= h_flags;
        end else begin
          case (rem)
            2'd3:    begin cmd_op <= OP_COMPUTE; cmd_flags <= FLG_START; end
            2'd2:    begin cmd_op <= OP_LOAD;    cmd_flags <= FLG_NONE;  end
            default: begin cmd_op <= OP_COMPUTE; cmd_flags <= FLG_STOP;  end
          endcase
        end
      end else if (req_fire) begin
        cmd_valid <= 1'b1;
        if (req_fp) begin
          cmd_op    <= OP_LOAD;
          cmd_flags <= FLG_NONE;
          rem       <= 2'd3;
        end else if (req_hit) begin
          cmd_op    <= OP_COMPUTE;
          cmd_flags <= req_flags;
          rem       <= 2'd0;
        end else begin
          cmd_op    <= OP_LOAD;
          cmd_flags <= FLG_NONE;
          rem       <= 2'd1;
        end
      end else begin
        cmd_valid <= 1'b0;
      end
    end
  end

  // Per-request payload held for the whole expansion
  always_ff @(posedge clk) begin
    if (req_fire) begin
      cmd_row_grp <= req_rgrp;
      cmd_col_grp <= req_cgrp;
      cmd_waddr   <= req_waddr;
      cmd_perf    <= req_perf;
      h_fp        <= req_fp;
      h_flags     <= req_flags;
    end
  end

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_op) && $stable(cmd_flags)
      && $stable(cmd_row_grp) && $stable(cmd_col_grp) && $stable(cmd_waddr) && $stable(cmd_perf));

  // R9
  load_then_compute_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && cmd_ready && (cmd_op == OP_LOAD) |=> cmd_valid && (cmd_op == OP_COMPUTE));

  // R3
  hit_compute_chk: assert property (@(posedge clk) disable iff (rst)
    req_fire && req_hit && !req_fp |=> cmd_valid && (cmd_op == OP_COMPUTE)
      && (cmd_flags == $past(req_flags)));

  // R4
  miss_load_chk: assert property (@(posedge clk) disable iff (rst)
    req_fire && !req_hit && !req_fp |=> cmd_valid && (cmd_op == OP_LOAD) && (cmd_flags == FLG_NONE));

  // R5
  fp_first_load_chk: assert property (@(posedge clk) disable iff (rst)
    req_fire && req_fp |=> cmd_valid && (cmd_op == OP_LOAD) && (cmd_flags == FLG_NONE));

  // R2
  grp_legal_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> (cmd_row_grp inside {4'h1, 4'h2, 4'h4, 4'h8, 4'h3, 4'hC, 4'hF})
      && (cmd_col_grp inside {4'h1, 4'h2, 4'h4, 4'h8, 4'h3, 4'hC, 4'hF}));
endmodule

// File: rtl/wtile_seq.sv
module wtile_seq
  import wtile_pkg::*;
#(
  parameter int ARRAY_DIM = 128,
  parameter int ADDR_W    = 16,
  parameter int PERF_W    = 3,
  localparam int POS_W    = $clog2(ARRAY_DIM),
  localparam int SIZE_W   = POS_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [POS_W-1:0]  req_row_pos,
  input  logic [SIZE_W-1:0] req_row_size,
  input  logic [POS_W-1:0]  req_col_pos,
  input  logic [SIZE_W-1:0] req_col_size,
  input  logic              req_col_full,
  input  logic [ADDR_W-1:0] req_waddr,
  input  logic [PERF_W-1:0] req_perf,
  input  logic              req_fullprec,
  input  logic [2:0]        req_flags,
  input  logic              tile_cfg_chg,
  input  logic              wr_snoop_valid,
  input  logic [ADDR_W-1:0] wr_snoop_addr,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic              cmd_op,
  output logic [3:0]        cmd_row_grp,
  output logic [3:0]        cmd_col_grp,
  output logic [ADDR_W-1:0] cmd_waddr,
  output logic [PERF_W-1:0] cmd_perf,
  output logic [2:0]        cmd_flags
);
  localparam int IDX_W = 2 * CLS_W;

  grp_t             rgrp, cgrp;
  logic [CLS_W-1:0] rcls, ccls;
  logic [IDX_W-1:0] key_idx;
  logic             hit, fire, clr_all, ins_en;

  wtile_grp_enc #(.ARRAY_DIM(ARRAY_DIM)) u_row_enc (
    .pos(req_row_pos), .size(req_row_size), .force_full(1'b0), .grp(rgrp), .cls(rcls));

  wtile_grp_enc #(.ARRAY_DIM(ARRAY_DIM)) u_col_enc (
    .pos(req_col_pos), .size(req_col_size), .force_full(req_col_full), .grp(cgrp), .cls(ccls));

  assign key_idx = {rcls, ccls};
  assign clr_all = tile_cfg_chg || (fire && req_fullprec);
  assign ins_en  = fire && !req_fullprec && !hit;

  wtile_tag_table #(.ADDR_W(ADDR_W), .PERF_W(PERF_W)) u_tags (
    .clk(clk), .rst(rst),
    .lk_idx(key_idx), .lk_addr(req_waddr), .lk_perf(req_perf), .lk_hit(hit),
    .clr_all(clr_all), .snoop_v(wr_snoop_valid), .snoop_addr(wr_snoop_addr),
    .ins_en(ins_en), .ins_idx(key_idx), .ins_addr(req_waddr), .ins_perf(req_perf));

  wtile_issue #(.ADDR_W(ADDR_W), .PERF_W(PERF_W)) u_issue (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_fp(req_fullprec), .req_hit(hit),
    .req_rgrp(rgrp), .req_cgrp(cgrp), .req_waddr(req_waddr), .req_perf(req_perf),
    .req_flags(req_flags), .req_fire(fire),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_row_grp(cmd_row_grp), .cmd_col_grp(cmd_col_grp), .cmd_waddr(cmd_waddr),
    .cmd_perf(cmd_perf), .cmd_flags(cmd_flags));

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    $past(rst) |-> !cmd_valid && req_ready);
endmodule

// File: tb/wtile_seq_bench.sv
module wtile_seq_bench;
  localparam int ARRAY_DIM = 128;
  localparam int ADDR_W = 16;
  localparam int PERF_W = 3;
  localparam int POS_W = 7;
  localparam int SIZE_W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [POS_W-1:0]  req_row_pos = '0;
  logic [SIZE_W-1:0] req_row_size = '0;
  logic [POS_W-1:0]  req_col_pos = '0;
  logic [SIZE_W-1:0] req_col_size = '0;
  logic req_col_full = 1'b0;
  logic [ADDR_W-1:0] req_waddr = '0;
  logic [PERF_W-1:0] req_perf = '0;
  logic req_fullprec = 1'b0;
  logic [2:0] req_flags = '0;
  logic tile_cfg_chg = 1'b0;
  logic wr_snoop_valid = 1'b0;
  logic [ADDR_W-1:0] wr_snoop_addr = '0;
  logic cmd_valid;
  logic cmd_ready = 1'b1;
  logic cmd_op;
  logic [3:0] cmd_row_grp, cmd_col_grp;
  logic [ADDR_W-1:0] cmd_waddr;
  logic [PERF_W-1:0] cmd_perf;
  logic [2:0] cmd_flags;

  wtile_seq #(.ARRAY_DIM(ARRAY_DIM), .ADDR_W(ADDR_W), .PERF_W(PERF_W)) u_wtile_seq (.*);

  always #5 clk = ~clk;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit mon_fire = 0;
  bit rand_ready = 0;
  string cur_tag = "R4";

  // Reference model state
  bit rv [64];
  int ra [64];
  int rp [64];
  logic [30:0] exp_q [$];
  string exp_tag [$];

  task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic int grp_of(int pos, int size, bit full);
    if (full) return 15;
    if (size <= 32) return 1 << (pos / 32);
    if (size <= 64) return (pos < 64) ? 3 : 12;
    return 15;
  endfunction

  function automatic int cls_of(int code);
    case (code)
      1: return 0;  2: return 1;  4: return 2;  8: return 3;
      3: return 4;  12: return 5; default: return 6;
    endcase
  endfunction

  task automatic push_exp(bit op, int rg, int cg, int addr, int perf, int flags);
    exp_q.push_back({op, 4'(rg), 4'(cg), 16'(addr), 3'(perf), 3'(flags)});
    exp_tag.push_back(cur_tag);
  endtask

  task automatic monitor_step();
    int q;
    q = exp_q.size();
    chk(cmd_valid == (q > 0), "R8", "cmd_valid", 32'(cmd_valid), 32'(q > 0));
    chk(req_ready == ((q == 0) || (q == 1 && cmd_ready)), "R8", "req_ready",
        32'(req_ready), 32'((q == 0) || (q == 1 && cmd_ready)));
    if (cmd_valid && cmd_ready && q > 0) begin
      logic [30:0] got;
      string t;
      got = {cmd_op, cmd_row_grp, cmd_col_grp, cmd_waddr, cmd_perf, cmd_flags};
      t = exp_tag.pop_front();
      chk(got == exp_q[0], t, "command (R9 order)", 32'(got), 32'(exp_q[0]));
      void'(exp_q.pop_front());
    end
    mon_fire = req_valid && req_ready;
    begin
      int rg, cg, idx;
      bit hit;
      rg = grp_of(int'(req_row_pos), int'(req_row_size), 1'b0);
      cg = grp_of(int'(req_col_pos), int'(req_col_size), req_col_full);
      idx = cls_of(rg) * 8 + cls_of(cg);
      hit = rv[idx] && ra[idx] == int'(req_waddr) && rp[idx] == int'(req_perf)
            && !tile_cfg_chg && !(wr_snoop_valid && ra[idx] == int'(wr_snoop_addr));
      if (mon_fire) begin
        if (req_fullprec) begin
          push_exp(0, rg, cg, req_waddr, req_perf, 0);
          push_exp(1, rg, cg, req_waddr, req_perf, 1);
          push_exp(0, rg, cg, req_waddr, req_perf, 0);
          push_exp(1, rg, cg, req_waddr, req_perf, 2);
        end else if (hit) begin
          push_exp(1, rg, cg, req_waddr, req_perf, req_flags);
        end else begin
          push_exp(0, rg, cg, req_waddr, req_perf, 0);
          push_exp(1, rg, cg, req_waddr, req_perf, req_flags);
        end
      end
      for (int i = 0; i < 64; i++) begin
        if (tile_cfg_chg || (mon_fire && req_fullprec)) rv[i] = 0;
        if (wr_snoop_valid && ra[i] == int'(wr_snoop_addr)) rv[i] = 0;
      end
      if (mon_fire && !req_fullprec && !hit) begin
        rv[idx] = 1; ra[idx] = int'(req_waddr); rp[idx] = int'(req_perf);
      end
    end
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (rand_ready) cmd_ready = ($urandom_range(0, 2) != 0);
      else cmd_ready = 1'b1;
      #4;
      if (!rst) monitor_step();
      else mon_fire = 0;
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        fails++;
        $display("FAIL R9 watchdog actual=%0d expected=%0d", cyc, 150000);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    end
  end

  task automatic send(int rpos, int rsize, int cpos, int csize, bit cfull, int addr, int perf,
                      bit fp, int flags, bit cfg = 0, bit snp = 0, int snp_addr = 0);
    @(negedge clk);
    req_valid = 1'b1;
    req_row_pos = POS_W'(rpos); req_row_size = SIZE_W'(rsize);
    req_col_pos = POS_W'(cpos); req_col_size = SIZE_W'(csize);
    req_col_full = cfull; req_waddr = ADDR_W'(addr); req_perf = PERF_W'(perf);
    req_fullprec = fp; req_flags = 3'(flags);
    tile_cfg_chg = cfg; wr_snoop_valid = snp; wr_snoop_addr = ADDR_W'(snp_addr);
    do @(posedge clk); while (!mon_fire);
    #1;
    tile_cfg_chg = 1'b0; wr_snoop_valid = 1'b0;
  endtask

  task automatic idle_drain();
    @(negedge clk);
    req_valid = 1'b0;
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic pulse(bit cfg, bit snp, int addr);
    @(negedge clk);
    req_valid = 1'b0;
    tile_cfg_chg = cfg; wr_snoop_valid = snp; wr_snoop_addr = ADDR_W'(addr);
    @(negedge clk);
    tile_cfg_chg = 1'b0; wr_snoop_valid = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin rv[i] = 0; ra[i] = 0; rp[i] = 0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk); #4;
    chk(cmd_valid == 1'b0, "R1", "cmd_valid after reset", 32'(cmd_valid), 0);
    chk(req_ready == 1'b1, "R1", "req_ready after reset", 32'(req_ready), 1);

    // R1 / R4: first request misses, then R3 hit back-to-back
    cur_tag = "R1"; send(0, 32, 0, 32, 0, 'h100, 0, 0, 3'b001);
    cur_tag = "R3"; send(0, 32, 0, 32, 0, 'h100, 0, 0, 3'b100);
    cur_tag = "R3"; send(0, 32, 0, 32, 0, 'h100, 0, 0, 3'b110);
    cur_tag = "R4"; send(0, 32, 32, 32, 0, 'h200, 0, 0, 3'b001);
    cur_tag = "R4"; send(0, 32, 0, 32, 0, 'h300, 0, 0, 3'b001);
    idle_drain();

    // R2: group encoding sweep
    cur_tag = "R2";
    send(96, 16, 64, 32, 0, 'h11, 0, 0, 0);
    send(40, 64, 100, 60, 0, 'h12, 0, 0, 0);
    send(0, 33, 127, 1, 0, 'h13, 0, 0, 0);
    send(64, 65, 10, 128, 0, 'h14, 0, 0, 0);
    send(32, 10, 0, 8, 1, 'h15, 0, 0, 0);
    send(32, 10, 96, 8, 1, 'h15, 0, 0, 0);
    idle_drain();

    // R10: perf mismatch misses
    cur_tag = "R10";
    send(0, 128, 0, 128, 0, 'h40, 1, 0, 4);
    send(0, 128, 0, 128, 0, 'h40, 2, 0, 4);
    send(0, 128, 0, 128, 0, 'h40, 2, 0, 4);
    idle_drain();

    // R7: snoop clears matching entries only
    cur_tag = "R7";
    send(64, 64, 0, 64, 0, 'h50, 0, 0, 1);
    send(0, 64, 0, 64, 0, 'h51, 0, 0, 1);
    idle_drain();
    pulse(0, 1, 'h50);
    send(64, 64, 0, 64, 0, 'h50, 0, 0, 2);
    send(0, 64, 0, 64, 0, 'h51, 0, 0, 2);
    idle_drain();
    send(0, 64, 0, 64, 0, 'h51, 0, 0, 2, 0, 1, 'h51);
    send(64, 64, 0, 64, 0, 'h50, 0, 0, 2, 0, 1, 'h99);
    idle_drain();

    // R6: tiling change clears everything
    cur_tag = "R6";
    pulse(1, 0, 0);
    send(0, 64, 0, 64, 0, 'h51, 0, 0, 4);
    send(0, 64, 0, 64, 0, 'h51, 0, 0, 4);
    send(0, 64, 0, 64, 0, 'h51, 0, 0, 4, 1, 0, 0);
    idle_drain();

    // R5: full precision expansion and invalidate
    cur_tag = "R5";
    send(0, 32, 0, 32, 0, 'h60, 0, 0, 1);
    send(0, 32, 0, 32, 0, 'h60, 0, 0, 1);
    send(32, 32, 0, 32, 1, 'h61, 0, 1, 7);
    send(0, 32, 0, 32, 0, 'h60, 0, 0, 1);
    idle_drain();

    // R8 / R9: random stream under backpressure
    cur_tag = "R8";
    rand_ready = 1;
    for (int n = 0; n < 400; n++) begin
      int pp [4] = '{0, 32, 64, 96};
      int ss [5] = '{16, 32, 48, 64, 128};
      send(pp[$urandom_range(0, 3)], ss[$urandom_range(0, 4)],
           pp[$urandom_range(0, 3)], ss[$urandom_range(0, 4)], ($urandom_range(0, 9) == 0),
           'h70 + $urandom_range(0, 2), $urandom_range(0, 1), ($urandom_range(0, 11) == 0),
           $urandom_range(0, 7), ($urandom_range(0, 39) == 0), ($urandom_range(0, 7) == 0),
           'h70 + $urandom_range(0, 2));
    end
    idle_drain();
    rand_ready = 0;
    chk(exp_q.size() == 0, "R9", "commands left over", 32'(exp_q.size()), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule